// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Two SRAM Model

This block is a synthesizable model of a pipelined synchronous SRAM with a double-data-rate data path and a fixed burst of two words. It runs on one system clock at twice the interface rate. A free-running two-bit slot counter splits every pair of interface clock periods into four system cycles. The even slots are the rising halves of the interface clock and the odd slots are the falling halves. Only slot 0 is an address-capture edge, so at most one command starts in each four-cycle frame.

A write collects two data words on the next interface rising and falling halves. It then sits in a posted buffer and reaches the array at the start of the next frame. No acknowledgement is needed from the host. A read returns both words of its pair in back-to-back system cycles, first at the requested address and then at that address with its least significant bit flipped. A latency-select input picks when the first word appears: one interface cycle after capture, or one and a half. The data bus is modelled as a separate input `d` and output `q` with a qualifying `q_valid`. An echo strobe toggles once for every word presented, so a receiver can capture data with it.

Top module: `sram_b2_ddr`

## Requirements
- R1: After reset `slot` is 0. It then counts 0,1,2,3,0,... once per clock. Slots 0 and 2 are interface-clock rising halves, slots 1 and 3 are falling halves, and only slot 0 is an address-capture slot.
- R2: A command is ignored and `cmd_ignored` is high for exactly the next cycle in two cases: `cmd_rd` or `cmd_wr` is high in a slot other than 0, or both are high in slot 0. An ignored command changes no array content and produces no read data.
- R3: A write accepted in slot 0 stores the `d` word of slot 2 at `addr` and the `d` word of slot 3 of the same frame at `addr` with bit 0 inverted. `d` is ignored in every other cycle.
- R4: A read returns `addr` as its first word and `addr` with bit 0 inverted as its second word. The upper address bits are the same for both words.
- R5: With `lat_sel`=0 sampled at the read's slot 0, `q_valid` is high in slots 2 and 3 of the same frame and nowhere else for that read.
- R6: With `lat_sel`=1 sampled at the read's slot 0, `q_valid` is high in slot 3 of the same frame and in slot 0 of the next frame.
- R7: `lat_sel` matters only in the slot in which a read is accepted. Changes during the rest of the frame do not move that read's words.
- R8: `q` is all zeros whenever `q_valid` is low.
- R9: `echo` is 0 after reset. It inverts in each cycle in which a read word is presented, so it is 1 during a first word and 0 during a second word, and it holds at all other times.
- R10: A read accepted in the frame right after a write returns the new data. This holds even though that write is still in the posted buffer.
- R11: While `rst` is high, `q_valid`, `q`, `echo` and `cmd_ignored` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at twice the interface rate |
| rst | input | 1 | Synchronous active-high reset |
| lat_sel | input | 1 | Read latency: 1 selects 1.5 interface cycles, 0 selects 1.0 |
| cmd_rd | input | 1 | Read request |
| cmd_wr | input | 1 | Write request |
| addr | input | ADDR_W | Word address of the burst's first word |
| d | input | WORD_W | Write data word |
| slot | output | 2 | Current slot within the four-cycle frame |
| q | output | WORD_W | Read data word, zero when not valid |
| q_valid | output | 1 | Read data present on `q` |
| echo | output | 1 | Strobe that inverts with every read word |
| cmd_ignored | output | 1 | One-cycle flag for a command that was not accepted |

## Verification
Several properties are checked on every cycle: the slot sequence, the silence of `q` between bursts, the fact that valid data never sits in slot 1, that bursts are exactly two words long and that a word in slot 0 always follows one in slot 3. The echo strobe is checked to move only with data, and the ignore flag to follow a read request off the capture slot. Only the bench's scenarios can show that the correct words come back in the correct order for both latencies and for addresses with either value of bit 0. The same goes for a read right after a write picking up the buffered data, and for stray commands and off-slot data leaving the array untouched.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;

    // Frame slots: even = interface clock high half, odd = low half.
    typedef enum logic [1:0] {
        SL_RISE_CAP = 2'd0,
        SL_FALL_CAP = 2'd1,
        SL_RISE_DAT = 2'd2,
        SL_FALL_DAT = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;
        logic ignored;
    } decode_t;

    localparam int WIDTH_NARROW = 18;
    localparam int WIDTH_WIDE   = 36;
    localparam int BURST_LEN    = 2;

    function automatic slot_e slot_after(input slot_e s);
        logic [1:0] n;
        n = s + 2'd1;
        return slot_e'(n);
    endfunction

    // A command is taken only in the capture slot and only when unambiguous.
    function automatic decode_t decode_cmd(input logic rd, input logic wr, input slot_e s);
        decode_t r;
        r.op      = OP_IDLE;
        r.ignored = 1'b0;
        if (rd || wr) begin
            if (s != SL_RISE_CAP || (rd && wr)) begin
                r.ignored = 1'b1;
            end else if (rd) begin
                r.op = OP_READ;
            end else begin
                r.op = OP_WRITE;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sram_b2_frame.sv
module sram_b2_frame
    import sram_b2_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_rd,
    input  logic  cmd_wr,
    output slot_e slot,
    output op_e   op,
    output logic  ignored
);

    decode_t dec;

    always_comb begin
        dec = decode_cmd(cmd_rd, cmd_wr, slot);
    end

    assign op = dec.op;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot    <= SL_RISE_CAP;
            ignored <= 1'b0;
        end else begin
            slot    <= slot_after(slot);
            ignored <= dec.ignored;
        end
    end

endmodule

// File: rtl/sram_b2_array.sv
module sram_b2_array #(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 6
) (
    input  logic                             clk,
    input  logic                             we,
    input  logic [ADDR_W-2:0]                wrow,
    input  logic [1:0][WORD_W-1:0]           wdata,
    input  logic [ADDR_W-2:0]                rrow,
    output logic [1:0][WORD_W-1:0]           rdata
);

    localparam int ROW_W = ADDR_W - 1;
    localparam int ROWS  = 1 << ROW_W;

    // One bank per address parity; a burst touches one row of both banks.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WORD_W-1:0] bank_mem [ROWS];

        always_ff @(posedge clk) begin
            if (we) begin
                bank_mem[wrow] <= wdata[b];
            end
        end

        assign rdata[b] = bank_mem[rrow];
    end

endmodule

// File: rtl/sram_b2_wrbuf.sv
module sram_b2_wrbuf
    import sram_b2_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  slot_e                  slot,
    input  op_e                    op,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [WORD_W-1:0]      d,
    output logic                   full,
    output logic                   commit,
    output logic [ADDR_W-2:0]      row,
    output logic [1:0][WORD_W-1:0] words
);

    logic armed;
    logic lsb;

    // The buffered pair goes to the array in the capture slot after it fills.
    assign commit = full && (slot == SL_RISE_CAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            full  <= 1'b0;
            armed <= 1'b0;
            row   <= '0;
            lsb   <= 1'b0;
            words <= '0;
        end else begin
            if (slot == SL_RISE_CAP) begin
                full  <= 1'b0;
                armed <= (op == OP_WRITE);
                if (op == OP_WRITE) begin
                    row <= addr[ADDR_W-1:1];
                    lsb <= addr[0];
                end
            end
            if (armed && slot == SL_RISE_DAT) begin
                words[lsb] <= d;
            end
            if (armed && slot == SL_FALL_DAT) begin
                words[~lsb] <= d;
                full        <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sram_b2_rdpipe.sv
module sram_b2_rdpipe
    import sram_b2_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  slot_e                  slot,
    input  op_e                    op,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   lat_sel,
    input  logic [1:0][WORD_W-1:0] arr_pair,
    input  logic                   wb_full,
    input  logic [ADDR_W-2:0]      wb_row,
    input  logic [1:0][WORD_W-1:0] wb_words,
    output logic [WORD_W-1:0]      q,
    output logic                   q_valid,
    output logic                   echo
);

    typedef struct packed {
        logic              valid;
        logic              slow;
        logic [WORD_W-1:0] first;
        logic [WORD_W-1:0] second;
    } pend_t;

    pend_t                   pend;
    logic                    fwd_hit;
    logic [1:0][WORD_W-1:0]  pair;
    logic                    ld_first;
    logic                    ld_second;

    // Bypass the array when the posted write covers the same row.
    assign fwd_hit = wb_full && (wb_row == addr[ADDR_W-1:1]);
    assign pair    = fwd_hit ? wb_words : arr_pair;

    always_comb begin
        ld_first  = 1'b0;
        ld_second = 1'b0;
        if (pend.valid) begin
            if (pend.slow) begin
                ld_first  = (slot == SL_RISE_DAT);
                ld_second = (slot == SL_FALL_DAT);
            end else begin
                ld_first  = (slot == SL_FALL_CAP);
                ld_second = (slot == SL_RISE_DAT);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            q       <= '0;
            q_valid <= 1'b0;
            echo    <= 1'b0;
        end else begin
            if (slot == SL_RISE_CAP) begin
                pend.valid <= (op == OP_READ);
                if (op == OP_READ) begin
                    pend.slow   <= lat_sel;
                    pend.first  <= pair[addr[0]];
                    pend.second <= pair[~addr[0]];
                end
            end
            q_valid <= ld_first || ld_second;
            if (ld_first) begin
                q <= pend.first;
            end else if (ld_second) begin
                q <= pend.second;
            end else begin
                q <= '0;
            end
            if (ld_first || ld_second) begin
                echo <= ~echo;
            end
        end
    end

endmodule

// File: rtl/sram_b2_ddr.sv
module sram_b2_ddr
    import sram_b2_pkg::*;
#(
    parameter int WORD_W = WIDTH_NARROW,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lat_sel,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] d,
    output logic [1:0]        slot,
    output logic [WORD_W-1:0] q,
    output logic              q_valid,
    output logic              echo,
    output logic              cmd_ignored
);

    localparam int ROW_W = ADDR_W - 1;

    slot_e                  slot_s;
    op_e                    op;
    logic                   wb_full;
    logic                   wb_commit;
    logic [ROW_W-1:0]       wb_row;
    logic [1:0][WORD_W-1:0] wb_words;
    logic [1:0][WORD_W-1:0] arr_pair;

    assign slot = slot_s;

    sram_b2_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .cmd_rd  (cmd_rd),
        .cmd_wr  (cmd_wr),
        .slot    (slot_s),
        .op      (op),
        .ignored (cmd_ignored)
    );

    sram_b2_wrbuf #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_wrbuf (
        .clk    (clk),
        .rst    (rst),
        .slot   (slot_s),
        .op     (op),
        .addr   (addr),
        .d      (d),
        .full   (wb_full),
        .commit (wb_commit),
        .row    (wb_row),
        .words  (wb_words)
    );

    sram_b2_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (wb_commit),
        .wrow  (wb_row),
        .wdata (wb_words),
        .rrow  (addr[ADDR_W-1:1]),
        .rdata (arr_pair)
    );

    sram_b2_rdpipe #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rdpipe (
        .clk      (clk),
        .rst      (rst),
        .slot     (slot_s),
        .op       (op),
        .addr     (addr),
        .lat_sel  (lat_sel),
        .arr_pair (arr_pair),
        .wb_full  (wb_full),
        .wb_row   (wb_row),
        .wb_words (wb_words),
        .q        (q),
        .q_valid  (q_valid),
        .echo     (echo)
    );

endmodule

// File: rtl/sram_b2_ddr_chk.sv
module sram_b2_ddr_chk #(
    parameter int WORD_W = 18,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_rd,
    input logic [1:0]        slot,
    input logic [WORD_W-1:0] q,
    input logic              q_valid,
    input logic              echo,
    input logic              cmd_ignored
);

    p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> slot == 2'($past(slot) + 2'd1));

    p_ignore_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd && slot != 2'd0) |=> cmd_ignored);

    p_no_data_slot1_r5: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> slot != 2'd1);

    p_burst_two_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(q_valid) |=> q_valid);

    p_burst_end_r5: assert property (@(posedge clk) disable iff (rst)
        (q_valid && $past(q_valid)) |=> !q_valid);

    p_slow_tail_r6: assert property (@(posedge clk) disable iff (rst)
        (q_valid && slot == 2'd0) |-> $past(q_valid));

    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (rst)
        !q_valid |-> q == '0);

    p_echo_data_r9: assert property (@(posedge clk) disable iff (rst)
        (echo != $past(echo)) |-> q_valid);

    p_echo_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(q_valid) |-> echo != $past(echo));

    p_reset_quiet_r11: assert property (@(posedge clk)
        $past(rst) |-> (!q_valid && !echo && !cmd_ignored));

endmodule

bind sram_b2_ddr sram_b2_ddr_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_rd      (cmd_rd),
    .slot        (slot),
    .q           (q),
    .q_valid     (q_valid),
    .echo        (echo),
    .cmd_ignored (cmd_ignored)
);

// File: tb/sram_b2_ddr_tb.sv
`timescale 1ns/1ps
module sram_b2_ddr_tb;

    localparam int W  = 18;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lat_sel = 1'b0;
    logic          cmd_rd = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  d = '0;
    logic [1:0]    slot;
    logic [W-1:0]  q;
    logic          q_valid;
    logic          echo;
    logic          cmd_ignored;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic exp_echo = 1'b0;

    bit           exp_v   [int];
    logic [W-1:0] exp_d   [int];
    string        exp_tag [int];
    bit           exp_ign [int];
    logic [W-1:0] ref_mem [int];

    always #2.5 clk = ~clk;

    sram_b2_ddr #(.WORD_W(W), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .lat_sel(lat_sel), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .addr(addr), .d(d), .slot(slot), .q(q), .q_valid(q_valid), .echo(echo),
        .cmd_ignored(cmd_ignored)
    );

    function automatic logic [W-1:0] junk();
        return W'({$urandom(), $urandom()});
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic check_cycle();
        bit v;
        chk("R1 slot", 64'(slot), 64'(cyc % 4));
        chk("R2 cmd_ignored", 64'(cmd_ignored), 64'(exp_ign.exists(cyc)));
        v = exp_v.exists(cyc);
        if (v) begin
            chk({exp_tag[cyc], " q_valid"}, 64'(q_valid), 64'd1);
            chk({exp_tag[cyc], " q data"}, 64'(q), 64'(exp_d[cyc]));
            exp_echo = ~exp_echo;
        end else begin
            chk("R5 R6 q_valid idle", 64'(q_valid), 64'd0);
            chk("R8 q quiet", 64'(q), 64'd0);
        end
        chk("R9 echo", 64'(echo), 64'(exp_echo));
    endtask

    task automatic step(input bit rd, input bit wr, input logic [AW-1:0] a,
                        input bit lat, input logic [W-1:0] dd);
        cmd_rd  = rd;
        cmd_wr  = wr;
        addr    = a;
        lat_sel = lat;
        d       = dd;
        @(negedge clk);
        cyc++;
        check_cycle();
    endtask

    task automatic idle_frame();
        for (int i = 0; i < 4; i++) step(0, 0, AW'($urandom()), 1'($urandom()), junk());
    endtask

    // R3: words on slots 2 and 3, junk on slots 0 and 1.
    task automatic wr_frame(input logic [AW-1:0] a, input logic [W-1:0] w0, input logic [W-1:0] w1);
        step(0, 1, a, 0, junk());
        step(0, 0, a, 0, junk());
        step(0, 0, a, 0, w0);
        step(0, 0, a, 0, w1);
        ref_mem[int'(a)]        = w0;
        ref_mem[int'(a ^ 6'd1)] = w1;
    endtask

    // R4/R5/R6/R7: schedule both words, then flip lat_sel after capture.
    task automatic rd_frame(input logic [AW-1:0] a, input bit lat, input string tag);
        int off;
        off = lat ? 3 : 2;
        exp_v[cyc + off]       = 1'b1;
        exp_d[cyc + off]       = ref_mem[int'(a)];
        exp_tag[cyc + off]     = {tag, " first word"};
        exp_v[cyc + off + 1]   = 1'b1;
        exp_d[cyc + off + 1]   = ref_mem[int'(a ^ 6'd1)];
        exp_tag[cyc + off + 1] = {tag, " second word"};
        step(1, 0, a, lat, junk());
        step(0, 0, a, ~lat, junk());
        step(0, 0, a, ~lat, junk());
        step(0, 0, a, ~lat, junk());
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset values while rst is high
        chk("R11 q_valid in reset", 64'(q_valid), 64'd0);
        chk("R11 q in reset", 64'(q), 64'd0);
        chk("R11 echo in reset", 64'(echo), 64'd0);
        chk("R11 cmd_ignored in reset", 64'(cmd_ignored), 64'd0);
        rst = 1'b0;
        cyc = 0;
        check_cycle();

        idle_frame();
        wr_frame(6'd4,  18'h11111, 18'h22222);
        wr_frame(6'd9,  18'h33333, 18'h04444);
        wr_frame(6'd12, 18'h05555, 18'h26666);
        wr_frame(6'd22, 18'h17777, 18'h38888);
        idle_frame();

        rd_frame(6'd4, 1'b0, "R4 R5 even addr");
        rd_frame(6'd5, 1'b0, "R4 R5 odd addr");
        rd_frame(6'd9, 1'b1, "R4 R6 odd addr");
        rd_frame(6'd8, 1'b1, "R4 R6 even addr");
        rd_frame(6'd12, 1'b1, "R7 R6 slow then fast");
        rd_frame(6'd22, 1'b0, "R7 R5 fast after slow");
        rd_frame(6'd13, 1'b1, "R7 R6 slow after fast");
        idle_frame();

        // R10: read directly behind a write to the same pair
        wr_frame(6'd30, 18'h0abcd, 18'h1bcde);
        rd_frame(6'd30, 1'b0, "R10 forward fast");
        wr_frame(6'd31, 18'h2cdef, 18'h0def1);
        rd_frame(6'd30, 1'b1, "R10 forward slow");
        wr_frame(6'd4,  18'h3f00f, 18'h10ff0);
        rd_frame(6'd5, 1'b1, "R10 overwrite");

        // R2: read in slot 1 is ignored
        step(0, 0, 6'd4, 0, junk());
        exp_ign[cyc + 1] = 1'b1;
        step(1, 0, 6'd4, 0, junk());
        step(0, 0, 6'd4, 0, junk());
        step(0, 0, 6'd4, 0, junk());

        // R2 R3: write in slot 2 is ignored and its data goes nowhere
        step(0, 0, 6'd12, 0, junk());
        step(0, 0, 6'd12, 0, junk());
        exp_ign[cyc + 1] = 1'b1;
        step(0, 1, 6'd12, 0, 18'h3eeee);
        step(0, 0, 6'd12, 0, 18'h3dddd);
        rd_frame(6'd12, 1'b0, "R2 R3 off-slot write left no trace");

        // R2: both commands at once are ignored
        exp_ign[cyc + 1] = 1'b1;
        step(1, 1, 6'd22, 0, junk());
        step(0, 0, 6'd22, 0, junk());
        step(0, 0, 6'd22, 0, 18'h00bad);
        step(0, 0, 6'd22, 0, 18'h00bee);
        rd_frame(6'd23, 1'b1, "R2 dual command left no trace");

        idle_frame();
        idle_frame();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule